// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block estimates the frequency of an intermediate-frequency signal by counting its rising edges over a fixed gate window whose length software picks from four settings. A control enable acts as both arm and trigger. While it is low, the count is held at zero and the block stays idle. When it goes from low to high, one measurement runs: first a short settling wait, then the gate window, and then the result is frozen until the enable is dropped again.

The IF input is taken as already synchronous to the system clock. A rising edge is a cycle where the input is seen high and the previous sample was low. The result is always visible in parallel. It can also be captured into a shift register and clocked out most significant bit first on a single serial line, for a narrow readout path.

Top module: `if_freq_counter`

## Requirements
- R1: After reset, result is 0, busy is 0, done is 0 and rd_bit is 0.
- R2: While en is 0, result is forced to 0 one cycle later and done and busy are 0.
- R3: A 0-to-1 change of en (sampled on consecutive clocks) starts a measurement: the next cycle shows busy=1, done=0 and result=0. Holding en at 1 never starts a second one.
- R4: Each measurement begins with WAIT_TICKS clock cycles of waiting, during which IF rising edges are not counted.
- R5: After the wait, a gate window of G x CLKS_PER_MS cycles follows. G is 4, 8, 32 or 64 for gate_sel codes 00, 01, 10 and 11. Every IF rising edge seen in a gate cycle adds one to result, so busy stays high for exactly WAIT_TICKS + G x CLKS_PER_MS cycles.
- R6: The count saturates at all ones (2^COUNT_W - 1) and never wraps.
- R7: At the end of the gate, done becomes 1 and busy 0, and result stays constant while en remains 1.
- R8: rd_load copies result into the readout register, and rd_bit then shows its most significant bit. Each rd_shift cycle moves to the next lower bit, with zeros filling in behind. rd_load wins over rd_shift in the same cycle.
- R9: gate_sel is captured at the start of a measurement; changing it later has no effect on that measurement's window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_in | input | 1 | IF signal, synchronous to clk |
| en | input | 1 | Count enable: low clears, rising edge starts |
| gate_sel | input | 2 | Gate time code |
| rd_load | input | 1 | Capture result into readout register |
| rd_shift | input | 1 | Advance readout register by one bit |
| result | output | COUNT_W | Current count |
| busy | output | 1 | Measurement in wait or gate phase |
| done | output | 1 | Measurement finished, result frozen |
| rd_bit | output | 1 | Serial readout bit, MSB first |

## Verification
The hardest condition to reach is saturation on the last cycle of a long gate window, together with an edge that falls exactly on the wait-to-gate boundary. The bench narrows the counter to six bits and shortens the millisecond, so that toggling the IF input every cycle through the longest window drives the count past all ones. A reference model tracks every cycle. Further runs change the IF pattern and the gate code in the middle of a measurement, so that the boundary edges and the captured gate code are both exercised.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_GATE = 2'd2,
        ST_DONE = 2'd3
    } ifc_state_e;

    // gate length in milliseconds for each select code
    function automatic int gate_ms(input logic [1:0] code);
        case (code)
            2'd0:    return 4;
            2'd1:    return 8;
            2'd2:    return 32;
            default: return 64;
        endcase
    endfunction
endpackage

// File: rtl/ifc_edge_det.sv
module ifc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_o
);
    logic sig_d, sig_q;

    always_comb sig_d = sig_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_d;
    end

    assign rise_o = sig_in & ~sig_q;
endmodule

// File: rtl/ifc_sat_inc.sv
module ifc_sat_inc #(
    parameter int W = 20
) (
    input  logic [W-1:0] val_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    always_comb begin
        if (inc_i && (val_i != ALL_ONES)) val_o = val_i + W'(1);
        else                              val_o = val_i;
    end
endmodule

// File: rtl/ifc_shift_out.sv
module ifc_shift_out #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] par_in,
    output logic         ser_o
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)       sh_d = par_in;
        else if (shift) sh_d = {sh_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign ser_o = sh_q[W-1];

    AST_MSB_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ser_o == $past(par_in[W-1]))); // R8
endmodule

// File: rtl/if_freq_counter.sv
module if_freq_counter #(
    parameter int COUNT_W     = 20,
    parameter int CLKS_PER_MS = 1000,
    parameter int WAIT_TICKS  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               if_in,
    input  logic               en,
    input  logic [1:0]         gate_sel,
    input  logic               rd_load,
    input  logic               rd_shift,
    output logic [COUNT_W-1:0] result,
    output logic               busy,
    output logic               done
    ,output logic              rd_bit
);
    import ifc_pkg::*;

    localparam int MAX_SPAN = 64 * CLKS_PER_MS + WAIT_TICKS;
    localparam int TIMER_W  = $clog2(MAX_SPAN) + 1;
    localparam logic [TIMER_W-1:0] WAIT_LAST = TIMER_W'(WAIT_TICKS - 1);

    typedef struct packed {
        ifc_state_e          state;
        logic [TIMER_W-1:0]  timer;
        logic [COUNT_W-1:0]  count;
        logic [1:0]          gsel;
        logic                en_prev;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic               if_rise;
    logic [COUNT_W-1:0] count_inc;
    logic [TIMER_W-1:0] gate_last;

    ifc_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (if_in),
        .rise_o (if_rise)
    );

    ifc_sat_inc #(.W(COUNT_W)) u_inc (
        .val_i (ctl_q.count),
        .inc_i (if_rise),
        .val_o (count_inc)
    );

    always_comb gate_last = TIMER_W'(gate_ms(ctl_q.gsel) * CLKS_PER_MS - 1);

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.en_prev = en;
        if (!en) begin
            ctl_d.state = ST_IDLE;
            ctl_d.timer = '0;
            ctl_d.count = '0;
        end else if (!ctl_q.en_prev) begin
            ctl_d.state = ST_WAIT;
            ctl_d.timer = '0;
            ctl_d.count = '0;
            ctl_d.gsel  = gate_sel;
        end else begin
            case (ctl_q.state)
                ST_WAIT: begin
                    if (ctl_q.timer == WAIT_LAST) begin
                        ctl_d.state = ST_GATE;
                        ctl_d.timer = '0;
                    end else begin
                        ctl_d.timer = ctl_q.timer + TIMER_W'(1);
                    end
                end
                ST_GATE: begin
                    ctl_d.count = count_inc;
                    if (ctl_q.timer == gate_last) begin
                        ctl_d.state = ST_DONE;
                        ctl_d.timer = '0;
                    end else begin
                        ctl_d.timer = ctl_q.timer + TIMER_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.timer   <= '0;
            ctl_q.count   <= '0;
            ctl_q.gsel    <= 2'd0;
            ctl_q.en_prev <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    ifc_shift_out #(.W(COUNT_W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (rd_load),
        .shift  (rd_shift),
        .par_in (ctl_q.count),
        .ser_o  (rd_bit)
    );

    assign result = ctl_q.count;
    assign busy   = (ctl_q.state == ST_WAIT) || (ctl_q.state == ST_GATE);
    assign done   = (ctl_q.state == ST_DONE);

    AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (result == '0 && !busy && !done)); // R2
    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> (busy && !done && result == '0)); // R3
    AST_WAIT_NOCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_WAIT) |-> (ctl_q.count == '0)); // R4
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(rst_n)) |-> (result >= $past(result))); // R6
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en) |=> (done && $stable(result))); // R7
endmodule

// File: tb/if_freq_counter_tb.sv
module if_freq_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 6;
    localparam int CPM  = 2;
    localparam int WT   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_in = 1'b0;
    logic en = 1'b0;
    logic [1:0] gate_sel = 2'd0;
    logic rd_load = 1'b0;
    logic rd_shift = 1'b0;
    logic [CW-1:0] result;
    logic busy, done, rd_bit;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // IF pattern: 0 hold, 1 toggle each cycle, 2 period 4, 3 lfsr
    int pat = 0;
    int ph = 0;
    logic [7:0] lfsr = 8'h5a;

    // reference model state
    int m_state = 0;
    int m_timer = 0;
    int m_cnt = 0;
    int m_gsel = 0;
    int m_sh = 0;
    bit m_prev_if = 0;
    bit m_prev_en = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    if_freq_counter #(.COUNT_W(CW), .CLKS_PER_MS(CPM), .WAIT_TICKS(WT)) u_dut (
        .clk(clk), .rst_n(rst_n), .if_in(if_in), .en(en), .gate_sel(gate_sel),
        .rd_load(rd_load), .rd_shift(rd_shift), .result(result),
        .busy(busy), .done(done), .rd_bit(rd_bit)
    );

    function automatic int glen(input int g);
        int ms;
        ms = (g == 0) ? 4 : (g == 1) ? 8 : (g == 2) ? 32 : 64;
        return ms * CPM;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_timer = 0; m_cnt = 0; m_gsel = 0; m_sh = 0;
            m_prev_if = 0; m_prev_en = 0;
        end else begin
            bit rise;
            int old_cnt;
            old_cnt = m_cnt;
            rise = if_in && !m_prev_if;
            if (!en) begin
                m_state = 0; m_timer = 0; m_cnt = 0;
            end else if (!m_prev_en) begin
                m_state = 1; m_timer = 0; m_cnt = 0; m_gsel = gate_sel;
            end else if (m_state == 1) begin
                if (m_timer == WT - 1) begin m_state = 2; m_timer = 0; end
                else m_timer++;
            end else if (m_state == 2) begin
                if (rise && m_cnt < (1 << CW) - 1) m_cnt++;
                if (m_timer == glen(m_gsel) - 1) begin m_state = 3; m_timer = 0; end
                else m_timer++;
            end
            if (rd_load) m_sh = old_cnt;
            else if (rd_shift) m_sh = (m_sh << 1) & ((1 << CW) - 1);
            m_prev_if = if_in;
            m_prev_en = en;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        chk("R5 result", int'(result), m_cnt);
        chk("R3 busy", int'(busy), int'(m_state == 1 || m_state == 2));
        chk("R7 done", int'(done), int'(m_state == 3));
        chk("R8 rd_bit", int'(rd_bit), (m_sh >> (CW - 1)) & 1);
        ph++;
        case (pat)
            1: if_in = ~if_in;
            2: if_in = ph[1];
            3: begin lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; if_in = lfsr[0]; end
            default: if_in = 1'b0;
        endcase
    endtask

    task automatic run_measure(input int code, output int busy_cycles);
        gate_sel = code[1:0];
        en = 1'b1;
        busy_cycles = 0;
        for (int i = 0; i < 400; i++) begin
            tick();
            if (busy) busy_cycles++;
            if (done) break;
        end
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int bc;
        logic [CW-1:0] snap;
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk("R1 result", int'(result), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 rd_bit", int'(rd_bit), 0);
        rst_n = 1'b1;
        tick(); tick();

        // short gate, toggling IF
        pat = 1;
        run_measure(0, bc);
        chk("R4 R5 busy span", bc, WT + glen(0));
        chk("R5 edge count", int'(result), glen(0) / 2);
        chk("R7 done set", int'(done), 1);
        snap = result;
        for (int i = 0; i < 5; i++) tick();
        chk("R7 result held", int'(result), int'(snap));
        chk("R3 no restart", int'(busy), 0);

        // serial readout of the held value
        rd_load = 1'b1; rd_shift = 1'b1; tick();
        rd_load = 1'b0;
        for (int b = CW - 1; b >= 0; b--) begin
            chk("R8 serial bit", int'(rd_bit), int'(snap[b]));
            tick();
        end
        chk("R8 zero fill", int'(rd_bit), 0);
        rd_shift = 1'b0;

        // clear
        en = 1'b0; tick();
        chk("R2 cleared", int'(result), 0);
        chk("R2 done low", int'(done), 0);
        tick();

        // code 01, period-4 IF, select changed mid-measurement
        pat = 2;
        gate_sel = 2'd1; en = 1'b1; tick();
        gate_sel = 2'd3;
        bc = 1;
        for (int i = 0; i < 400; i++) begin
            tick();
            if (busy) bc++;
            if (done) break;
        end
        chk("R9 window kept", bc, WT + glen(1));
        chk("R5 period4 count", int'(result), glen(1) / 4);
        en = 1'b0; tick();

        // saturation on the longest gate
        pat = 1;
        run_measure(3, bc);
        chk("R6 saturated", int'(result), (1 << CW) - 1);
        en = 1'b0; tick();

        // pseudo-random IF on code 10, then restart by dropping en one cycle
        pat = 3;
        run_measure(2, bc);
        chk("R5 lfsr span", bc, WT + glen(2));
        en = 1'b0; tick();
        pat = 2;
        run_measure(0, bc);
        chk("R3 restart span", bc, WT + glen(0));
        for (int i = 0; i < 4; i++) tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule